// File: doc/BRIEF.md
# Phase-Frequency Detector with Lock Flag

This block is the digital comparison stage of one frequency-synthesizer channel. An internal 11-bit reference divider counts down the system clock and emits a one-cycle reference tick every programmed number of cycles. The block detects rising edges on the feedback divider's carry and compares them with the reference ticks. It then raises pump-up or pump-down requests for an external charge pump. When both requests are set, they stay set together for a fixed minimum overlap and then drop together. A phase error of zero therefore still gives a short equal pulse on both outputs, so the transfer curve has no dead zone.

The controls are plain level pins. One pin swaps the two pump outputs to invert the loop polarity. A 3-bit pump-current code is passed on through one register. A power-on input stops the divider and the detector without disturbing the configuration. A lock flag drops for each cycle in which a one-sided pump request has already lasted the programmed window. Its pulse count thus shows how far the loop is from lock. The block moves no data stream, so it has no valid/ready handshake.

Top module: `pfd_chan`

## Requirements
- R1: While `rst_n` is low, `pump_up`, `pump_dn` and `ref_tick` are 0, `lock_ok` is 1 and `cp_code` is 0.
- R2: With `pwr_on` high, `ref_tick` is a one-cycle pulse every D cycles, where D is the effective divide value. The first pulse comes in the cycle after the D-th clock edge at which `pwr_on` is high.
- R3: `pump_up` goes high in the cycle after a `ref_tick` pulse. `pump_dn` goes high in the cycle after the first cycle in which `fb_in` is high following a low cycle (a rising edge).
- R4: Once both requests are set, both stay high for exactly OVL_CYC (default 2) cycles and then drop together. Coincident edges therefore give an OVL_CYC-cycle pulse on both outputs.
- R5: A set request without its partner stays high across further reference ticks. It drops only through the overlap release in R4.
- R6: With `cfg_invert` at 1, the detector's up request drives `pump_dn` and its down request drives `pump_up`.
- R7: A run is a series of consecutive cycles in which exactly one of the pump outputs is high. In the k-th cycle of a run (k from 0), `lock_ok` is 0 when k is at least `cfg_win`; in every other cycle `lock_ok` is 1. The count saturates at 15.
- R8: `cp_code` equals the `cfg_cp_code` value from the previous clock edge, whether `pwr_on` is high or low.
- R9: One edge after `pwr_on` is sampled low, both pump outputs and `ref_tick` are 0 and `lock_ok` is 1. `fb_in` edges are ignored while power is off. When power returns, the divider restarts from its full value.
- R10: A `cfg_rdiv` value below 3 acts as a divide value of 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwr_on | input | 1 | Enables the divider and the detector |
| cfg_rdiv | input | 11 | Reference divide value (values below 3 are treated as 3) |
| cfg_invert | input | 1 | Swaps the pump outputs |
| cfg_cp_code | input | 3 | Pump current code |
| cfg_win | input | 4 | Lock window, in cycles |
| fb_in | input | 1 | Feedback divider carry (level; its rising edge is used) |
| ref_tick | output | 1 | Reference divider carry pulse |
| pump_up | output | 1 | Pump-up request |
| pump_dn | output | 1 | Pump-down request |
| cp_code | output | 3 | Registered pump current code |
| lock_ok | output | 1 | Lock flag; low pulses mark excess one-sided pumping |

## Verification
Each result arrives a fixed number of edges after its cause. The reference tick appears after the D-th powered edge. A pump output appears one edge after its tick or its feedback rise. The overlap release comes OVL_CYC cycles after both requests are set. The lock flag and the pump outputs come straight from flops in the same cycle, and `cp_code` lags its input by one edge. The bench drives every input on the falling edge and samples there. For each scenario it counts the high or low cycles of every output over a window of exactly 2·D cycles after power-on. That window holds the whole pump event and stops before the second tick can set a request again. Expected counts come from the feedback offset d: the leading output is high for |d|+OVL_CYC cycles, the other for OVL_CYC cycles, and `lock_ok` is low for max(0, |d|−`cfg_win`) cycles.

// File: rtl/pfd_chan_pkg.sv
package pfd_chan_pkg;

  localparam int unsigned RDIV_FLOOR = 3;

  typedef struct packed {
    logic up;
    logic dn;
  } pump_pair_t;

  function automatic pump_pair_t orient_pair(input pump_pair_t p, input logic swap);
    pump_pair_t o;
    o.up = swap ? p.dn : p.up;
    o.dn = swap ? p.up : p.dn;
    return o;
  endfunction

endpackage

// File: rtl/pfd_chan_refdiv.sv
module pfd_chan_refdiv
  import pfd_chan_pkg::*;
#(
  parameter int unsigned RDIV_W = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic [RDIV_W-1:0] cfg_div,
  output logic              tick
);

  localparam logic [RDIV_W-1:0] FLOOR = RDIV_W'(RDIV_FLOOR);
  localparam logic [RDIV_W-1:0] ONE   = RDIV_W'(1);

  logic [RDIV_W-1:0] div_eff;
  logic [RDIV_W-1:0] cnt_q;
  logic              tick_q;

  // R10: small programmed values are lifted to the floor
  always_comb div_eff = (cfg_div < FLOOR) ? FLOOR : cfg_div;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= FLOOR;
      tick_q <= 1'b0;
    end else if (!en) begin
      cnt_q  <= div_eff;
      tick_q <= 1'b0;
    end else if (cnt_q <= ONE) begin
      cnt_q  <= div_eff;
      tick_q <= 1'b1;
    end else begin
      cnt_q  <= cnt_q - ONE;
      tick_q <= 1'b0;
    end
  end

  assign tick = tick_q;

  p_tick_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
    tick_q |=> !tick_q);

  p_tick_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !tick_q);

endmodule

// File: rtl/pfd_chan_core.sv
module pfd_chan_core
  import pfd_chan_pkg::*;
#(
  parameter int unsigned OVL_CYC = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en,
  input  logic       ref_evt,
  input  logic       fb_lvl,
  output pump_pair_t pair
);

  localparam int unsigned OVL_W = (OVL_CYC < 2) ? 1 : $clog2(OVL_CYC);
  localparam logic [OVL_W-1:0] LAST = OVL_W'(OVL_CYC - 1);

  logic             fb_q;
  logic             fb_rise;
  logic             up_q, dn_q;
  logic [OVL_W-1:0] ovl_q;
  logic             both;
  logic             drop;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) fb_q <= 1'b0;
    else        fb_q <= fb_lvl;
  end

  always_comb begin
    fb_rise = fb_lvl & ~fb_q;
    both    = up_q & dn_q;
    drop    = both && (ovl_q == LAST);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      up_q  <= 1'b0;
      dn_q  <= 1'b0;
      ovl_q <= '0;
    end else if (!en) begin
      up_q  <= 1'b0;
      dn_q  <= 1'b0;
      ovl_q <= '0;
    end else begin
      up_q  <= (up_q & ~drop) | ref_evt;
      dn_q  <= (dn_q & ~drop) | fb_rise;
      ovl_q <= (both && !drop) ? ovl_q + 1'b1 : '0;
    end
  end

  assign pair.up = up_q;
  assign pair.dn = dn_q;

  p_up_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (en && ref_evt) |=> up_q);

  p_dn_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (en && fb_rise) |=> dn_q);

  p_release_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (en && both && ovl_q == LAST && !ref_evt && !fb_rise) |=> (!up_q && !dn_q));

  p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (en && up_q && !dn_q && !fb_rise) |=> up_q);

  p_off_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (!up_q && !dn_q));

endmodule

// File: rtl/pfd_chan_lockdet.sv
module pfd_chan_lockdet
  import pfd_chan_pkg::*;
#(
  parameter int unsigned WIN_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  pump_pair_t       pair,
  input  logic [WIN_W-1:0] cfg_win,
  output logic             lock_ok
);

  localparam logic [WIN_W-1:0] SAT = {WIN_W{1'b1}};

  logic             single;
  logic [WIN_W-1:0] run_q;

  always_comb single = pair.up ^ pair.dn;

  // R7: length of the current one-sided run, saturating
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            run_q <= '0;
    else if (!single)      run_q <= '0;
    else if (run_q != SAT) run_q <= run_q + 1'b1;
  end

  always_comb lock_ok = !(single && (run_q >= cfg_win));

  p_run_restart_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !single |=> (run_q == '0));

endmodule

// File: rtl/pfd_chan.sv
module pfd_chan
  import pfd_chan_pkg::*;
#(
  parameter int unsigned RDIV_W  = 11,
  parameter int unsigned CP_W    = 3,
  parameter int unsigned WIN_W   = 4,
  parameter int unsigned OVL_CYC = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pwr_on,
  input  logic [RDIV_W-1:0] cfg_rdiv,
  input  logic              cfg_invert,
  input  logic [CP_W-1:0]   cfg_cp_code,
  input  logic [WIN_W-1:0]  cfg_win,
  input  logic              fb_in,
  output logic              ref_tick,
  output logic              pump_up,
  output logic              pump_dn,
  output logic [CP_W-1:0]   cp_code,
  output logic              lock_ok
);

  pump_pair_t       det_pair;
  pump_pair_t       out_pair;
  logic [CP_W-1:0]  cp_q;
  logic             seen_q;

  pfd_chan_refdiv #(.RDIV_W(RDIV_W)) u_refdiv (
    .clk     (clk),
    .rst_n   (rst_n),
    .en      (pwr_on),
    .cfg_div (cfg_rdiv),
    .tick    (ref_tick)
  );

  pfd_chan_core #(.OVL_CYC(OVL_CYC)) u_core (
    .clk     (clk),
    .rst_n   (rst_n),
    .en      (pwr_on),
    .ref_evt (ref_tick),
    .fb_lvl  (fb_in),
    .pair    (det_pair)
  );

  pfd_chan_lockdet #(.WIN_W(WIN_W)) u_lock (
    .clk     (clk),
    .rst_n   (rst_n),
    .pair    (det_pair),
    .cfg_win (cfg_win),
    .lock_ok (lock_ok)
  );

  // R6: polarity applied after detection
  always_comb out_pair = orient_pair(det_pair, cfg_invert);
  assign pump_up = out_pair.up;
  assign pump_dn = out_pair.dn;

  // R8: code register, kept during power-down
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cp_q   <= '0;
      seen_q <= 1'b0;
    end else begin
      cp_q   <= cfg_cp_code;
      seen_q <= 1'b1;
    end
  end
  assign cp_code = cp_q;

  p_cp_follow_r8: assert property (@(posedge clk) disable iff (!rst_n)
    seen_q |=> (cp_code == $past(cfg_cp_code)));

  p_lock_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(pump_up ^ pump_dn) |-> lock_ok);

endmodule

// File: tb/pfd_chan_tb_top.sv
`timescale 1ns/1ps
module pfd_chan_tb_top;

  localparam int OVL = 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        pwr_on = 1'b0;
  logic [10:0] cfg_rdiv = 11'd20;
  logic        cfg_invert = 1'b0;
  logic [2:0]  cfg_cp_code = 3'd6;
  logic [3:0]  cfg_win = 4'd0;
  logic        fb_in = 1'b0;
  logic        ref_tick, pump_up, pump_dn, lock_ok;
  logic [2:0]  cp_code;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  pfd_chan dut_i (
    .clk(clk), .rst_n(rst_n), .pwr_on(pwr_on), .cfg_rdiv(cfg_rdiv),
    .cfg_invert(cfg_invert), .cfg_cp_code(cfg_cp_code), .cfg_win(cfg_win),
    .fb_in(fb_in), .ref_tick(ref_tick), .pump_up(pump_up), .pump_dn(pump_dn),
    .cp_code(cp_code), .lock_ok(lock_ok)
  );

  // {rdiv[10:0], offset d signed[7:0], invert, win[3:0]}
  localparam logic [23:0] VECS [0:5] = '{
    {11'd20,  8'sd3, 1'b0, 4'd1},
    {11'd20, -8'sd4, 1'b0, 4'd2},
    {11'd16,  8'sd0, 1'b0, 4'd0},
    {11'd20,  8'sd5, 1'b1, 4'd5},
    {11'd24, -8'sd6, 1'b1, 4'd3},
    {11'd12,  8'sd7, 1'b0, 4'd0}
  };

  task automatic chk(input string req, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  // power-cycle, then count outputs over 2*R cycles; fb rises d cycles after the tick
  task automatic run_vec(input int r, input int d, input bit inv, input int win);
    int n_up = 0, n_dn = 0, n_low = 0, n_tick = 0;
    int lead, exp_up, exp_dn, exp_low;
    @(negedge clk);
    pwr_on = 1'b0; fb_in = 1'b0;
    cfg_rdiv = 11'(r); cfg_invert = inv; cfg_win = 4'(win);
    repeat (2) @(negedge clk);
    pwr_on = 1'b1;
    for (int k = 1; k <= 2 * r; k++) begin
      @(negedge clk);
      fb_in = (k == r + d);
      n_up   += int'(pump_up);
      n_dn   += int'(pump_dn);
      n_low  += int'(!lock_ok);
      n_tick += int'(ref_tick);
    end
    fb_in = 1'b0;
    lead = (d < 0) ? -d : d;
    exp_up = (d >= 0) ? lead + OVL : OVL;
    exp_dn = (d >= 0) ? OVL : lead + OVL;
    if (inv) begin
      int t = exp_up; exp_up = exp_dn; exp_dn = t;
    end
    exp_low = (lead > win) ? lead - win : 0;
    chk("R2 tick count", n_tick, 2);
    chk(inv ? "R6 pump_up width (R3 R4)" : "R3 pump_up width (R4)", n_up, exp_up);
    chk(inv ? "R6 pump_dn width (R3 R4)" : "R3 pump_dn width (R4)", n_dn, exp_dn);
    chk("R7 lock low cycles", n_low, exp_low);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      n_fail++;
      n_run++;
      $display("FAIL watchdog: got 0 expected 1");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    int first, n_up, n_dn, n_low, n_tick;
    // R1 reset state
    repeat (3) @(negedge clk);
    chk("R1 pump_up", int'(pump_up), 0);
    chk("R1 pump_dn", int'(pump_dn), 0);
    chk("R1 ref_tick", int'(ref_tick), 0);
    chk("R1 lock_ok", int'(lock_ok), 1);
    chk("R1 cp_code", int'(cp_code), 0);
    rst_n = 1'b1;

    // table of scenarios
    for (int v = 0; v < 6; v++) begin
      run_vec(int'(VECS[v][23:13]), int'($signed(VECS[v][12:5])),
              VECS[v][4], int'(VECS[v][3:0]));
    end

    // R8 code register, powered and unpowered
    @(negedge clk); pwr_on = 1'b1; cfg_cp_code = 3'd5;
    @(negedge clk); chk("R8 cp_code on", int'(cp_code), 5);
    pwr_on = 1'b0; cfg_cp_code = 3'd2;
    @(negedge clk); chk("R8 cp_code off", int'(cp_code), 2);

    // R10 divide floor: rdiv=1 behaves as 3
    cfg_rdiv = 11'd1; cfg_invert = 1'b0; fb_in = 1'b0;
    repeat (2) @(negedge clk);
    pwr_on = 1'b1; first = 0; n_tick = 0;
    for (int k = 1; k <= 9; k++) begin
      @(negedge clk);
      n_tick += int'(ref_tick);
      if (ref_tick && first == 0) first = k;
    end
    chk("R10 first tick", first, 3);
    chk("R10 tick count", n_tick, 3);

    // R5 up held over repeated ticks without feedback; R7 saturating window
    @(negedge clk); pwr_on = 1'b0; cfg_rdiv = 11'd10; cfg_win = 4'd15;
    repeat (2) @(negedge clk);
    pwr_on = 1'b1; n_up = 0; n_dn = 0; n_low = 0;
    for (int k = 1; k <= 30; k++) begin
      @(negedge clk);
      n_up += int'(pump_up); n_dn += int'(pump_dn); n_low += int'(!lock_ok);
    end
    chk("R5 pump_up held", n_up, 20);
    chk("R5 pump_dn idle", n_dn, 0);
    chk("R7 saturated low cycles", n_low, 5);

    // R9 power off clears outputs and ignores feedback; restart from full count
    pwr_on = 1'b0; fb_in = 1'b1;
    @(negedge clk);
    chk("R9 pump_up off", int'(pump_up), 0);
    chk("R9 ref_tick off", int'(ref_tick), 0);
    chk("R9 lock_ok off", int'(lock_ok), 1);
    fb_in = 1'b0;
    @(negedge clk);
    pwr_on = 1'b1; first = 0; n_dn = 0; n_up = 0;
    for (int k = 1; k <= 10; k++) begin
      @(negedge clk);
      n_dn += int'(pump_dn); n_up += int'(pump_up);
      if (ref_tick && first == 0) first = k;
    end
    chk("R9 feedback ignored", n_dn, 0);
    chk("R9 no stale up", n_up, 0);
    chk("R9 restart tick", first, 10);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule